// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block gathers single-cycle event pulses from up to 32 sources into a sticky status word, and raises one host interrupt line. Software picks which status bits may reach the line through an enable word. It clears serviced bits by writing ones to the status word. To keep the host from taking an interrupt per event, the line is held back by a hold-off timer. That timer counts an external 32 microsecond tick, up to a programmed 8-bit number of ticks.

A high-priority receive event skips the hold-off entirely and raises the line on the next clock. A second byte in the configuration word turns on a periodic receive event, generated every N ticks, which lands in status like any other source. All ports are plain control and status signals. There is no data stream, so there is no valid/ready handshake: a write happens on any clock where the write strobe is high, and read data follows the address with no clock in between.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0, the configuration word reads 0x00000040 (hold-off 64 ticks, periodic off), and `irq` is low.
- R2: A pulse on `src_evt[i]` sets status bit i on the next clock. The bit stays set until the host writes a 1 to it at address 0. Writing 0 to a bit leaves it unchanged.
- R3: If a hardware set and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Status bits whose enable bit (address 1) is 0 still latch, but never raise `irq`.
- R5: With a hold-off of 0, `irq` rises on the clock after an enabled status bit becomes visible. That is two clocks after the event pulse.
- R6: With a hold-off of N>0, the timer loads on the clock after an enabled bit becomes visible, while the line is idle. It counts only cycles with `tick_32us` high. `irq` rises on the clock that takes the Nth counted tick.
- R7: Once high, `irq` stays high until no enabled status bit remains. It falls on the clock after the last enabled bit clears.
- R8: A pulse on `hipri_evt` sets status bit 31. When enable bit 31 is set, `irq` rises on the next clock, whatever the timer state.
- R9: Configuration bits [15:8] give a period P in ticks. When P is nonzero, status bit 28 is set on every Pth tick. When P is 0, the periodic source is off and its count resets.
- R10: If every enabled status bit clears while the hold-off runs, the timer is dropped and `irq` stays low.
- R11: Register map: address 0 is status (write 1 to clear), address 1 is enable, address 2 is configuration ([7:0] hold-off, [15:8] period, other bits read 0), and address 3 reads 0. Source bit roles: 31 receive DMA, 29 hardware error, 28 periodic receive, 27 transmit DMA, 25 firmware error, 7 kill switch, 1 wakeup, 0 alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_evt | input | 32 | Source event pulses, one per status bit |
| hipri_evt | input | 1 | High-priority receive event, bypasses hold-off |
| tick_32us | input | 1 | One-cycle pulse every 32 us |
| irq | output | 1 | Host interrupt line |

## Verification
The hardest cases to reach from the ports are the races. One is a host clear landing in the same cycle as a hardware set of the same bit. The other is a clear that empties the enabled set partway through a hold-off. The bench reaches both by turning off the free-running tick and stepping ticks by hand. This places the clear write a known number of ticks into the count, or in the exact cycle of the event pulse. A long random phase then mixes events, writes, priority pulses and small hold-off and period values. A behavioural model is compared against the line and the read data on every cycle.

// File: rtl/ico_pkg.sv
package ico_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_COAL   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    HOLD_IDLE = 2'd0,
    HOLD_WAIT = 2'd1,
    HOLD_FIRE = 2'd2
  } hold_state_e;

  // Source roles within the status word
  localparam int BIT_RX_DMA      = 31;
  localparam int BIT_HW_ERR      = 29;
  localparam int BIT_RX_PERIODIC = 28;
  localparam int BIT_TX_DMA      = 27;
  localparam int BIT_FW_ERR      = 25;
  localparam int BIT_KILL_SW     = 7;
  localparam int BIT_WAKE        = 1;
  localparam int BIT_ALIVE       = 0;

endpackage

// File: rtl/ico_status_bank.sv
module ico_status_bank #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] stat_q
);

  // One sticky cell per bit; a set in the same cycle beats a clear.
  for (genvar b = 0; b < STAT_W; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        stat_q[b] <= 1'b0;
      else if (set_vec[b])
        stat_q[b] <= 1'b1;
      else if (clr_vec[b])
        stat_q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/ico_period_gen.sv
module ico_period_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             fire
);

  localparam int CNT_W = PER_W + 1;

  logic [PER_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             active;

  assign active  = (period != '0);
  assign cnt_inc = {1'b0, cnt_q} + CNT_W'(1);
  assign fire    = tick && active && (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n || !active)
      cnt_q <= '0;
    else if (fire)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_inc[PER_W-1:0];
  end

endmodule

// File: rtl/ico_hold_timer.sv
module ico_hold_timer
  import ico_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [TMR_W-1:0] timeout,
  input  logic             pending,
  input  logic             bypass,
  output logic             irq,
  output logic [1:0]       state_o
);

  hold_state_e      state_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= HOLD_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        HOLD_IDLE: begin
          if (bypass)
            state_q <= HOLD_FIRE;
          else if (pending) begin
            if (timeout == '0)
              state_q <= HOLD_FIRE;
            else begin
              state_q <= HOLD_WAIT;
              cnt_q   <= timeout;
            end
          end
        end
        HOLD_WAIT: begin
          if (bypass)
            state_q <= HOLD_FIRE;
          else if (!pending)
            state_q <= HOLD_IDLE;
          else if (tick) begin
            if (cnt_q == TMR_W'(1))
              state_q <= HOLD_FIRE;
            else
              cnt_q <= cnt_q - TMR_W'(1);
          end
        end
        HOLD_FIRE: begin
          if (!pending && !bypass)
            state_q <= HOLD_IDLE;
        end
        default: state_q <= HOLD_IDLE;
      endcase
    end
  end

  assign irq     = (state_q == HOLD_FIRE);
  assign state_o = state_q;

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import ico_pkg::*;
#(
  parameter int              STAT_W      = 32,
  parameter int              TMR_W       = 8,
  parameter int              PER_W       = 8,
  parameter int              ADDR_W      = 2,
  parameter int              HIPRI_BIT   = 31,
  parameter int              PER_BIT     = 28,
  parameter logic [TMR_W-1:0] TIMEOUT_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] src_evt,
  input  logic              hipri_evt,
  input  logic              tick_32us,
  output logic              irq
);

  localparam int CFG_USED = TMR_W + PER_W;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_q;
  logic [TMR_W-1:0]  to_q;
  logic [PER_W-1:0]  per_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic              per_fire;
  logic              pending;
  logic              bypass;
  logic [1:0]        hold_state;
  logic              wr_stat, wr_en, wr_cfg;

  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));
  assign wr_en   = reg_wr && (reg_addr == ADDR_W'(REG_ENABLE));
  assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(REG_COAL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      to_q  <= TIMEOUT_RST;
      per_q <= '0;
    end else begin
      if (wr_en)
        en_q <= reg_wdata;
      if (wr_cfg) begin
        to_q  <= reg_wdata[TMR_W-1:0];
        per_q <= reg_wdata[CFG_USED-1:TMR_W];
      end
    end
  end

  always_comb begin
    set_vec            = src_evt;
    set_vec[HIPRI_BIT] = src_evt[HIPRI_BIT] | hipri_evt;
    set_vec[PER_BIT]   = src_evt[PER_BIT] | per_fire;
  end

  assign clr_vec = wr_stat ? reg_wdata : '0;
  assign pending = |(stat_q & en_q);
  assign bypass  = hipri_evt && en_q[HIPRI_BIT];

  ico_status_bank #(.STAT_W(STAT_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  ico_period_gen #(.PER_W(PER_W)) u_period (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_32us),
    .period (per_q),
    .fire   (per_fire)
  );

  ico_hold_timer #(.TMR_W(TMR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_32us),
    .timeout (to_q),
    .pending (pending),
    .bypass  (bypass),
    .irq     (irq),
    .state_o (hold_state)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(REG_STATUS): reg_rdata = stat_q;
      ADDR_W'(REG_ENABLE): reg_rdata = en_q;
      ADDR_W'(REG_COAL): begin
        reg_rdata[TMR_W-1:0]        = to_q;
        reg_rdata[CFG_USED-1:TMR_W] = per_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ico_checker.sv
module ico_checker
  import ico_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int TMR_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int HIPRI_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [STAT_W-1:0] src_evt,
  input logic              hipri_evt,
  input logic              irq,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q,
  input logic [TMR_W-1:0]  to_q,
  input logic [1:0]        hold_state
);

  logic pend_w, byp_w, clr_w;
  assign pend_w = |(stat_q & en_q);
  assign byp_w  = hipri_evt && en_q[HIPRI_BIT];
  assign clr_w  = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_w |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((stat_q & $past(src_evt)) == $past(src_evt)));

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pend_w) && !$past(byp_w)) |-> !irq);

  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_state == 2'(HOLD_IDLE) && pend_w && to_q == '0) |=> irq);

  a_r7_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && pend_w) |=> irq);

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    byp_w |=> irq);

endmodule

bind irq_coalesce_ctrl ico_checker #(
  .STAT_W    (STAT_W),
  .TMR_W     (TMR_W),
  .ADDR_W    (ADDR_W),
  .HIPRI_BIT (HIPRI_BIT)
) u_ico_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .src_evt    (src_evt),
  .hipri_evt  (hipri_evt),
  .irq        (irq),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .to_q       (to_q),
  .hold_state (hold_state)
);

// File: tb/test_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module test_irq_coalesce_ctrl;

  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] src_evt = '0;
  logic        hipri_evt = 1'b0;
  logic        tick_32us;
  logic        irq;

  logic       auto_tick = 1'b0;
  logic       auto_t = 1'b0;
  logic       man_tick = 1'b0;
  logic [1:0] tcnt = '0;
  assign tick_32us = auto_tick ? auto_t : man_tick;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= tcnt + 2'd1;
    auto_t <= (tcnt == 2'd0);
  end

  irq_coalesce_ctrl i_irq_coalesce_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_evt   (src_evt),
    .hipri_evt (hipri_evt),
    .tick_32us (tick_32us),
    .irq       (irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_stat, m_en, m_set, m_clr;
  int          m_to, m_per, m_cnt, m_pcnt, m_st; // m_st: 0 idle, 1 counting, 2 line high
  bit          m_pend, m_byp, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_to = 64; m_per = 0;
      m_cnt = 0; m_pcnt = 0; m_st = 0;
    end else begin
      m_fire = tick_32us && (m_per != 0) && (m_pcnt + 1 >= m_per);
      m_set  = src_evt;
      if (hipri_evt) m_set[31] = 1'b1;
      if (m_fire)    m_set[28] = 1'b1;
      m_clr  = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;
      m_pend = (m_stat & m_en) != 0;
      m_byp  = hipri_evt && m_en[31];
      if (m_st == 0) begin
        if (m_byp) m_st = 2;
        else if (m_pend) begin
          if (m_to == 0) m_st = 2;
          else begin m_st = 1; m_cnt = m_to; end
        end
      end else if (m_st == 1) begin
        if (m_byp) m_st = 2;
        else if (!m_pend) m_st = 0;
        else if (tick_32us) begin
          if (m_cnt == 1) m_st = 2;
          else m_cnt = m_cnt - 1;
        end
      end else begin
        if (!m_pend && !m_byp) m_st = 0;
      end
      if (m_per == 0) m_pcnt = 0;
      else if (m_fire) m_pcnt = 0;
      else if (tick_32us) m_pcnt = m_pcnt + 1;
      m_stat = (m_stat & ~m_clr) | m_set;
      if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
      if (reg_wr && reg_addr == 2'd2) begin
        m_to  = int'(reg_wdata[7:0]);
        m_per = int'(reg_wdata[15:8]);
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = m_stat;
      2'd1: m_read = m_en;
      2'd2: m_read = {16'h0, 8'(m_per), 8'(m_to)};
      default: m_read = '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, midway between edges
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R6 irq vs model", {31'h0, irq}, {31'h0, (m_st == 2)});
      chk("R11 read vs model", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic mtick();
    man_tick = 1'b1;
    @(negedge clk);
    man_tick = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(WD_CYC * 20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(2'd0, 32'h0, "R1 status after reset");
    rd_chk(2'd1, 32'h0, "R1 enable after reset");
    rd_chk(2'd2, 32'h40, "R1 config after reset");
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R4 masked source latches, line stays low
    pulse(32'h80);
    rd_chk(2'd0, 32'h80, "R4 masked bit latched");
    cyc(40);
    chk("R4 masked irq", {31'h0, irq}, 32'h0);

    // R2 write 0 keeps, write 1 clears
    wr(2'd0, 32'h0);
    rd_chk(2'd0, 32'h80, "R2 zero write keeps bit");
    wr(2'd0, 32'h80);
    rd_chk(2'd0, 32'h0, "R2 one write clears bit");

    // R3 set and clear collide
    src_evt = 32'h0800_0000;
    wr(2'd0, 32'h0800_0000);
    src_evt = '0;
    rd_chk(2'd0, 32'h0800_0000, "R3 set beats clear");
    wr(2'd0, 32'hFFFF_FFFF);

    // R5 zero hold-off
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h1);
    pulse(32'h1);
    chk("R5 irq not yet", {31'h0, irq}, 32'h0);
    cyc(1);
    chk("R5 irq raised", {31'h0, irq}, 32'h1);

    // R7 falls after clear
    wr(2'd0, 32'h1);
    chk("R7 irq held during clear", {31'h0, irq}, 32'h1);
    cyc(1);
    chk("R7 irq dropped", {31'h0, irq}, 32'h0);

    // R6 hold-off of 3 ticks, hand-stepped
    wr(2'd2, 32'h3);
    wr(2'd1, 32'h2);
    pulse(32'h2);
    cyc(1);
    mtick(); cyc(2); mtick(); cyc(3);
    chk("R6 irq after two ticks", {31'h0, irq}, 32'h0);
    mtick();
    chk("R6 irq after third tick", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h2);
    cyc(1);
    chk("R7 irq low after clear", {31'h0, irq}, 32'h0);

    // R10 clear during hold-off abandons the timer
    pulse(32'h2);
    cyc(1);
    mtick();
    wr(2'd0, 32'h2);
    for (int k = 0; k < 5; k++) begin mtick(); cyc(1); end
    chk("R10 irq stays low", {31'h0, irq}, 32'h0);

    // R8 priority bypass with long hold-off
    wr(2'd2, 32'hFF);
    wr(2'd1, 32'h8000_0000);
    hipri_evt = 1'b1;
    @(negedge clk);
    hipri_evt = 1'b0;
    chk("R8 irq next clock", {31'h0, irq}, 32'h1);
    rd_chk(2'd0, 32'h8000_0000, "R8 bit 31 set");
    wr(2'd0, 32'h8000_0000);
    cyc(1);
    chk("R8 irq low after clear", {31'h0, irq}, 32'h0);

    // R9 periodic source every 5 ticks
    wr(2'd1, 32'h0);
    auto_tick = 1'b1;
    wr(2'd2, 32'h0000_05FF);
    wr(2'd0, 32'hFFFF_FFFF);
    cyc(10);
    rd_chk(2'd0, 32'h0, "R9 no periodic before period");
    cyc(12);
    rd_chk(2'd0, 32'h1000_0000, "R9 periodic bit set");
    wr(2'd2, 32'h0000_00FF);
    wr(2'd0, 32'hFFFF_FFFF);
    cyc(60);
    rd_chk(2'd0, 32'h0, "R9 periodic off");

    // R11 map: spare address and unused config bits
    wr(2'd2, 32'hFFFF_FF12);
    rd_chk(2'd2, 32'h0000_FF12, "R11 config upper bits read 0");
    rd_chk(2'd3, 32'h0, "R11 spare address reads 0");
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h0, "R11 spare write no effect");

    // random mix, compared each cycle against the model
    for (int i = 0; i < 4000; i++) begin
      src_evt   = ($urandom % 8 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      hipri_evt = ($urandom % 50 == 0);
      reg_wr    = ($urandom % 6 == 0);
      reg_addr  = 2'($urandom % 4);
      reg_wdata = (reg_addr == 2'd2) ? ($urandom & 32'h0000_0F07) : $urandom;
      @(negedge clk);
    end
    src_evt = '0; hipri_evt = 1'b0; reg_wr = 1'b0;
    cyc(4);
    report();
    $finish;
  end

endmodule